// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits next to a memory subordinate and watches the read and write requests that reach it. Each request carries a manager ID, a byte address and a flag that marks it as exclusive. An exclusive read reserves the addressed granule for the ID that issued it. A later exclusive write from that ID is let through only if no performed write has touched the granule since the reservation was taken.

For every observed write the monitor answers in the same cycle. It gives a response code and a commit strobe, and the memory uses the strobe to gate its write enable. A failed exclusive write is kept away from memory and gets the plain OKAY code, so the manager has to start its read-modify-write sequence again. Other managers keep full access to memory the whole time. Only a write that lands inside a reserved granule cancels a reservation.

The table holds one entry per ID. Addresses are aligned down to a granule of 2**GRAN_LSB bytes before they are compared.

Top module: `exmon_top`

## Requirements
- R1: After reset no reservation exists, so an exclusive write gets OKAY (code 2'b00) and `wr_commit_o` low.
- R2: An exclusive read from ID n, followed by an exclusive write from ID n to the same granule with no conflicting write between them, gets EXOKAY (code 2'b01) with `wr_commit_o` high in the cycle the write is presented.
- R3: Addresses are compared after dropping the low GRAN_LSB bits. With the default GRAN_LSB of 3, the addresses 0x100 and 0x104 match, and 0x200 and 0x208 do not.
- R4: A performed write from any ID into a reserved granule cancels that reservation. The owner's later exclusive write then gets OKAY and is not committed.
- R5: Performed writes to other granules and failed exclusive writes leave a reservation intact.
- R6: A new exclusive read from an ID replaces that ID's earlier reservation.
- R7: Every exclusive write, whether it succeeds or fails, clears the writer's own reservation.
- R8: A failed exclusive write is not committed and does not cancel the reservations of other IDs.
- R9: A normal (non-exclusive) write is always committed and answered with OKAY.
- R10: The read response is EXOKAY for an exclusive read and OKAY for any other read, in the same cycle.
- R11: If an exclusive read and a write to the same granule arrive in the same cycle, the write is judged against the old table and the new reservation survives.
- R12: Several IDs can reserve the same granule. The first successful exclusive write cancels the reservations of all the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid_i | input | 1 | Read request observed this cycle |
| rd_id_i | input | ID_W | Manager ID of the read |
| rd_addr_i | input | ADDR_W | Byte address of the read |
| rd_excl_i | input | 1 | Read is exclusive |
| rd_resp_o | output | 2 | Read response code (00 OKAY, 01 EXOKAY) |
| wr_valid_i | input | 1 | Write request observed this cycle |
| wr_id_i | input | ID_W | Manager ID of the write |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_excl_i | input | 1 | Write is exclusive |
| wr_resp_o | output | 2 | Write response code (00 OKAY, 01 EXOKAY) |
| wr_commit_o | output | 1 | Write may update memory |

## Verification
The hardest case to reach is a read reservation and a conflicting write landing in the same cycle. The result then depends on the order in which the clear and the set act on one entry. The scoreboard stimulus presents both requests on the same clock, then sends an exclusive write from the reading ID to show that the reservation survived. A second hard case is a failed exclusive write aimed at someone else's reserved granule. To reach it, the stimulus sends an exclusive write from an ID that holds no reservation, then shows that the real owner still succeeds.

// File: rtl/exmon_pkg.sv
package exmon_pkg;
   typedef enum logic [1:0] {
      RESP_OKAY   = 2'b00,
      RESP_EXOKAY = 2'b01
   } xresp_e;
endpackage

// File: rtl/exmon_entry.sv
module exmon_entry #(
   parameter int TAG_W = 29
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic [TAG_W-1:0] set_tag_i,
   input  logic             kill_i,
   output logic             vld_o,
   output logic [TAG_W-1:0] tag_o
);
   // a new reservation wins over a clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         tag_o <= '0;
      end else if (set_i) begin
         vld_o <= 1'b1;
         tag_o <= set_tag_i;
      end else if (kill_i) begin
         vld_o <= 1'b0;
      end
   end
endmodule

// File: rtl/exmon_decide.sv
module exmon_decide
   import exmon_pkg::*;
#(
   parameter int TAG_W = 29
) (
   input  logic             wr_valid_i,
   input  logic             wr_excl_i,
   input  logic             own_vld_i,
   input  logic [TAG_W-1:0] own_tag_i,
   input  logic [TAG_W-1:0] wr_tag_i,
   output logic [1:0]       resp_o,
   output logic             commit_o
);
   logic hit;
   always_comb begin
      hit      = own_vld_i && (own_tag_i == wr_tag_i);
      resp_o   = RESP_OKAY;
      commit_o = 1'b0;
      if (wr_valid_i) begin
         if (!wr_excl_i) begin
            commit_o = 1'b1;
         end else if (hit) begin
            commit_o = 1'b1;
            resp_o   = RESP_EXOKAY;
         end
      end
   end
endmodule

// File: rtl/exmon_top.sv
module exmon_top
   import exmon_pkg::*;
#(
   parameter int NUM_IDS  = 4,
   parameter int ADDR_W   = 32,
   parameter int GRAN_LSB = 3,
   localparam int ID_W    = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1,
   localparam int TAG_W   = ADDR_W - GRAN_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_valid_i,
   input  logic [ID_W-1:0]   rd_id_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic              rd_excl_i,
   output logic [1:0]        rd_resp_o,
   input  logic              wr_valid_i,
   input  logic [ID_W-1:0]   wr_id_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic              wr_excl_i,
   output logic [1:0]        wr_resp_o,
   output logic              wr_commit_o
);
   if (NUM_IDS < 2 || (1 << ID_W) != NUM_IDS) begin : g_bad_ids
      $error("exmon_top: NUM_IDS must be a power of two of at least 2");
   end
   if (GRAN_LSB < 0 || GRAN_LSB >= ADDR_W) begin : g_bad_gran
      $error("exmon_top: GRAN_LSB must lie inside the address");
   end

   logic [TAG_W-1:0] rd_tag, wr_tag;
   assign rd_tag = rd_addr_i[ADDR_W-1:GRAN_LSB];
   assign wr_tag = wr_addr_i[ADDR_W-1:GRAN_LSB];

   if (GRAN_LSB > 0) begin : g_low_bits
      logic unused_low;
      assign unused_low = ^{rd_addr_i[GRAN_LSB-1:0], wr_addr_i[GRAN_LSB-1:0]};
   end

   logic [NUM_IDS-1:0] ent_vld;
   logic [TAG_W-1:0]   ent_tag [NUM_IDS];
   logic               rd_xset;
   logic               wr_xany;

   assign rd_xset = rd_valid_i && rd_excl_i;
   assign wr_xany = wr_valid_i && wr_excl_i;

   for (genvar g = 0; g < NUM_IDS; g++) begin : g_ent
      logic set_g, kill_g;
      assign set_g  = rd_xset && (rd_id_i == ID_W'(g));
      assign kill_g = (wr_commit_o && ent_vld[g] && (ent_tag[g] == wr_tag))
                    || (wr_xany && (wr_id_i == ID_W'(g)));
      exmon_entry #(.TAG_W(TAG_W)) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_i     (set_g),
         .set_tag_i (rd_tag),
         .kill_i    (kill_g),
         .vld_o     (ent_vld[g]),
         .tag_o     (ent_tag[g])
      );
   end

   exmon_decide #(.TAG_W(TAG_W)) u_dec (
      .wr_valid_i (wr_valid_i),
      .wr_excl_i  (wr_excl_i),
      .own_vld_i  (ent_vld[wr_id_i]),
      .own_tag_i  (ent_tag[wr_id_i]),
      .wr_tag_i   (wr_tag),
      .resp_o     (wr_resp_o),
      .commit_o   (wr_commit_o)
   );

   assign rd_resp_o = rd_xset ? RESP_EXOKAY : RESP_OKAY;
endmodule

// File: rtl/exmon_chk.sv
module exmon_chk #(
   parameter int ID_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rd_valid_i,
   input logic [ID_W-1:0] rd_id_i,
   input logic            rd_excl_i,
   input logic [1:0]      rd_resp_o,
   input logic            wr_valid_i,
   input logic [ID_W-1:0] wr_id_i,
   input logic            wr_excl_i,
   input logic [1:0]      wr_resp_o,
   input logic            wr_commit_o
);
   logic seen_xrd;
   always_ff @(posedge clk) begin
      if (!rst_n) seen_xrd <= 1'b0;
      else if (rd_valid_i && rd_excl_i) seen_xrd <= 1'b1;
   end

   // R1
   no_early_exok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen_xrd && wr_valid_i && wr_excl_i) |-> (wr_resp_o == 2'b00 && !wr_commit_o));

   // R8
   fail_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_i && wr_excl_i && wr_resp_o == 2'b00) |-> !wr_commit_o);

   // R9
   plain_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_i && !wr_excl_i) |-> (wr_commit_o && wr_resp_o == 2'b00));

   // R10
   rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_resp_o == ((rd_valid_i && rd_excl_i) ? 2'b01 : 2'b00));

   // R7
   own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_i && wr_excl_i && wr_resp_o == 2'b01
       && !(rd_valid_i && rd_excl_i && rd_id_i == wr_id_i))
      |=> !(wr_valid_i && wr_excl_i && wr_id_i == $past(wr_id_i) && wr_resp_o == 2'b01));

   // R2
   resp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_resp_o == 2'b01) |-> (wr_valid_i && wr_excl_i && wr_commit_o));
endmodule

bind exmon_top exmon_chk #(.ID_W(ID_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_valid_i  (rd_valid_i),
   .rd_id_i     (rd_id_i),
   .rd_excl_i   (rd_excl_i),
   .rd_resp_o   (rd_resp_o),
   .wr_valid_i  (wr_valid_i),
   .wr_id_i     (wr_id_i),
   .wr_excl_i   (wr_excl_i),
   .wr_resp_o   (wr_resp_o),
   .wr_commit_o (wr_commit_o)
);

// File: tb/exmon_top_tb_top.sv
module exmon_top_tb_top;
   localparam int CLK_PER = 10;
   localparam int ID_W    = 2;
   localparam int ADDR_W  = 32;

   typedef struct {
      int         req;
      logic       chk_w;
      logic [1:0] exp_wresp;
      logic       exp_commit;
      logic [1:0] exp_rresp;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rd_valid = 1'b0, rd_excl = 1'b0;
   logic [ID_W-1:0]   rd_id = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic              wr_valid = 1'b0, wr_excl = 1'b0;
   logic [ID_W-1:0]   wr_id = '0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [1:0]        rd_resp, wr_resp;
   logic              wr_commit;

   exp_t exp_q[$];
   int   n_chk = 0, n_fail = 0;
   bit   done = 0;

   always #(CLK_PER/2) clk = ~clk;

   exmon_top #(.NUM_IDS(4), .ADDR_W(ADDR_W), .GRAN_LSB(3)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .rd_valid_i(rd_valid), .rd_id_i(rd_id), .rd_addr_i(rd_addr),
      .rd_excl_i(rd_excl), .rd_resp_o(rd_resp),
      .wr_valid_i(wr_valid), .wr_id_i(wr_id), .wr_addr_i(wr_addr),
      .wr_excl_i(wr_excl), .wr_resp_o(wr_resp), .wr_commit_o(wr_commit)
   );

   // one cycle of stimulus plus its expectation
   task automatic op(input logic rv, input logic re, input int rid, input int ra,
                     input logic wv, input logic we, input int wid, input int wa,
                     input int req, input logic [1:0] ewr, input logic ec,
                     input logic [1:0] err);
      exp_t e;
      @(posedge clk);
      #1;
      rd_valid = rv; rd_excl = re; rd_id = ID_W'(rid); rd_addr = ADDR_W'(ra);
      wr_valid = wv; wr_excl = we; wr_id = ID_W'(wid); wr_addr = ADDR_W'(wa);
      e.req = req; e.chk_w = wv; e.exp_wresp = ewr; e.exp_commit = ec; e.exp_rresp = err;
      exp_q.push_back(e);
   endtask

   task automatic xrd(input int id, input int a, input int req);
      op(1, 1, id, a, 0, 0, 0, 0, req, 2'b00, 1'b0, 2'b01);
   endtask

   task automatic wrt(input logic ex, input int id, input int a, input int req,
                      input logic [1:0] ewr, input logic ec);
      op(0, 0, 0, 0, 1, ex, id, a, req, ewr, ec, 2'b00);
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (rd_resp !== e.exp_rresp) begin
               n_fail++;
               $display("FAIL R%0d rd_resp got %b exp %b", e.req, rd_resp, e.exp_rresp);
            end
            if (e.chk_w) begin
               n_chk++;
               if (wr_resp !== e.exp_wresp || wr_commit !== e.exp_commit) begin
                  n_fail++;
                  $display("FAIL R%0d wr_resp/commit got %b/%b exp %b/%b",
                           e.req, wr_resp, wr_commit, e.exp_wresp, e.exp_commit);
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      wrt(1, 0, 'h100, 1, 2'b00, 0);        // R1: nothing reserved after reset
      xrd(0, 'h100, 10);                     // R10: exclusive read answered EXOKAY
      op(1, 0, 1, 'h200, 0, 0, 0, 0, 10, 2'b00, 0, 2'b00); // R10: normal read OKAY
      wrt(1, 0, 'h104, 2, 2'b01, 1);        // R2 and R3: same granule succeeds
      wrt(1, 0, 'h100, 7, 2'b00, 0);        // R7: own entry cleared by success
      xrd(1, 'h200, 3);
      wrt(1, 1, 'h208, 3, 2'b00, 0);        // R3: next granule does not match
      wrt(1, 1, 'h200, 7, 2'b00, 0);        // R7: failed write also cleared the entry
      xrd(2, 'h300, 4);
      wrt(0, 3, 'h304, 9, 2'b00, 1);        // R9: normal write committed, OKAY
      wrt(1, 2, 'h300, 4, 2'b00, 0);        // R4: reservation lost to the write
      xrd(2, 'h300, 5);
      wrt(0, 3, 'h310, 5, 2'b00, 1);        // R5: other granule
      wrt(1, 1, 'h300, 5, 2'b00, 0);        // R5: failed write from a non-owner
      wrt(1, 2, 'h306, 5, 2'b01, 1);        // R5: reservation intact
      xrd(3, 'h500, 6);
      xrd(3, 'h600, 6);
      wrt(1, 3, 'h500, 6, 2'b00, 0);        // R6: old address replaced
      xrd(3, 'h700, 6);
      xrd(3, 'h800, 6);
      wrt(1, 3, 'h800, 6, 2'b01, 1);        // R6: newest address holds
      xrd(0, 'h900, 8);
      wrt(1, 1, 'h900, 8, 2'b00, 0);        // R8: failed write, not committed
      wrt(1, 0, 'h900, 8, 2'b01, 1);        // R8: owner unaffected
      xrd(0, 'hA00, 12);
      xrd(1, 'hA00, 12);
      wrt(1, 0, 'hA00, 12, 2'b01, 1);       // R12: first one wins
      wrt(1, 1, 'hA00, 12, 2'b00, 0);       // R12: second one cancelled
      op(1, 1, 2, 'hB00, 1, 0, 3, 'hB04, 11, 2'b00, 1, 2'b01); // R11: same cycle
      wrt(1, 2, 'hB00, 11, 2'b01, 1);       // R11: reservation survived
      op(0, 0, 0, 0, 0, 0, 0, 0, 10, 2'b00, 0, 2'b00); // R10: idle read OKAY
      @(posedge clk); #1;
      rd_valid = 0; wr_valid = 0;
      repeat (3) @(posedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule